// File: doc/BRIEF.md
# Dual-mode watchdog interval timer

An 8-bit up-counter driven by a selectable prescaler. One control/status register decides its role. In interval mode, each wrap of the counter from 0xFF to 0x00 latches an overflow flag, and that flag drives an interrupt request. In watchdog mode, a wrap instead raises an external overflow pulse, and the flag stays untouched. Software reaches the control/status register (address 0) and the counter (address 1) over a simple single-cycle register bus. A write is accepted only when the upper byte of the 16-bit write word carries the right key.

The overflow flag is held by a three-state machine.

- `FLG_CLEAR`: no overflow pending.
- `FLG_PENDING`: the flag is set but has not yet been seen by software.
- `FLG_ARMED`: the flag is set and was read as 1.

The transitions are:

- `FLG_CLEAR -> FLG_PENDING` on an interval-mode wrap.
- `FLG_PENDING -> FLG_ARMED` on a read of address 0.
- `FLG_ARMED -> FLG_CLEAR` on a keyed write with bit 7 = 0.
- `FLG_ARMED -> FLG_PENDING` on any other write to address 0, or on a new interval wrap.
- Any state returns to `FLG_CLEAR` on power-on reset or standby.

Top module: `wdt_interval_timer`

## Requirements
- R1: Address 0 reads as {flag[7], mode[6] (1 = watchdog, 0 = interval), enable[5], 1, 1, clock select[2:0]}. Address 1 reads the counter.
- R2: After power-on reset, address 0 reads 0x18, the counter reads 0, and irq, wd_ovf and ovf_flag are 0.
- R3: Bits 4 and 3 of address 0 always read 1, whatever was written to them.
- R4: In interval mode, the flag sets on the edge where the counter wraps from 0xFF to 0x00. It never sets in watchdog mode. irq equals the flag.
- R5: The flag clears only through a keyed write with bit 7 = 0 that follows a read of address 0 returning the flag as 1. The read arms the clear. Writing 1 to bit 7 has no effect. Any write to address 0, keyed or not, disarms.
- R6: While enable is 0, the counter holds 0 and counter writes are ignored.
- R7: While enabled, the counter steps by one every N clocks. N is 2, 64, 128, 256, 512, 1024, 4096 or 8192 for clock select 0 to 7, and the first step comes N clocks after enable rises.
- R8: A write to address 0 is accepted only when bus_wdata[15:8] = 0xA5. A write to address 1 is accepted only when bus_wdata[15:8] = 0x5A. Its value comes from bus_wdata[7:0].
- R9: In watchdog mode, a wrap drives wd_ovf high from that edge until the next prescaler tick, which is N clocks.
- R10: Standby clears mode, enable and the flag, and keeps the clock select. Writes to address 0 made during standby are ignored. Power-on reset also clears the clock select.
- R11: When an interval wrap and a clearing write fall on the same edge, the flag stays set.
- R12: When a counter write falls on a prescaler tick edge, the written value is loaded without the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| standby | input | 1 | Standby indication, synchronous, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 16 | Key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interval interrupt request |
| wd_ovf | output | 1 | Watchdog overflow pulse |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The functions that collide are the interval wrap setting the flag and the software write that clears it. The bench first arms the clear by reading address 0. It then counts cycles from the enable edge and places the clearing write exactly on the edge of the second wrap. The flag must still be 1 afterward, and a fresh read-and-clear must then succeed. A second collision, a counter write on a prescaler tick edge, is judged by reading back the written value unchanged and seeing it step only one period later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        FLG_CLEAR   = 2'd0,
        FLG_PENDING = 2'd1,
        FLG_ARMED   = 2'd2
    } flag_state_e;

    // log2 of the prescaler divide ratio for each clock-select code
    function automatic int unsigned div_shift(input logic [2:0] sel);
        int unsigned sh;
        unique case (sel)
            3'd0:    sh = 1;
            3'd1:    sh = 6;
            3'd2:    sh = 7;
            3'd3:    sh = 8;
            3'd4:    sh = 9;
            3'd5:    sh = 10;
            3'd6:    sh = 12;
            default: sh = 13;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PRE_W = 13
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       tick
);
    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_W'((32'd1 << div_shift(cks)) - 32'd1);
        tick  = run && (pc_q >= limit);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            pc_q <= '0;
        else if (!run || tick)
            pc_q <= '0;
        else
            pc_q <= pc_q + PRE_W'(1);
    end

    // R7: ticks are separated by at least one idle cycle (ratio >= 2)
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    always_comb wrap = run && tick && !load && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            count <= '0;
        else if (!run)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick)
            count <= count + CNT_W'(1);
    end

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> (count == '0));

    assert_step_R7: assert property (@(posedge clk) disable iff (!por_n)
        (run && tick && !load) |=> (count == $past(count) + CNT_W'(1)));

    assert_load_wins_R12: assert property (@(posedge clk) disable iff (!por_n)
        (run && load) |=> (count == $past(load_val)));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       standby,
    input  logic       ctrl_wr,
    input  logic       wr_touch,
    input  logic       rd_flag,
    input  logic       wrap,
    input  logic       tick,
    input  logic [7:0] wdata,
    output logic       mode,
    output logic       run,
    output logic [2:0] cks,
    output logic       flag,
    output logic       wd_pulse
);
    flag_state_e state_q, state_d;
    logic        set_evt;

    always_comb set_evt = wrap && !mode;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= FLG_CLEAR;
        else if (standby)
            state_q <= FLG_CLEAR;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (set_evt) state_d = FLG_PENDING;
            FLG_PENDING: if (rd_flag) state_d = FLG_ARMED;
            FLG_ARMED: begin
                if (set_evt)
                    state_d = FLG_PENDING;
                else if (ctrl_wr && !wdata[7])
                    state_d = FLG_CLEAR;
                else if (wr_touch)
                    state_d = FLG_PENDING;
            end
            default:     state_d = FLG_CLEAR;
        endcase
    end

    // outputs
    always_comb flag = (state_q != FLG_CLEAR);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mode <= 1'b0;
            run  <= 1'b0;
            cks  <= 3'd0;
        end else if (standby) begin
            mode <= 1'b0;
            run  <= 1'b0;
        end else if (ctrl_wr) begin
            mode <= wdata[6];
            run  <= wdata[5];
            cks  <= wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            wd_pulse <= 1'b0;
        else if (standby)
            wd_pulse <= 1'b0;
        else if (wrap && mode)
            wd_pulse <= 1'b1;
        else if (tick)
            wd_pulse <= 1'b0;
    end

    assert_wd_no_flag_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!flag && !(wrap && !mode)) |=> !flag);

    assert_keep_unarmed_R5: assert property (@(posedge clk) disable iff (!por_n)
        (flag && state_q != FLG_ARMED && !standby) |=> flag);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!por_n)
        (wrap && !mode && !standby) |=> flag);

    assert_wd_pulse_R9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_pulse) |-> $past(wrap && mode));

    assert_standby_R10: assert property (@(posedge clk) disable iff (!por_n)
        standby |=> (!run && !mode && !flag && cks == $past(cks)));

endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
    import wdt_pkg::*;
#(
    parameter int         CNT_W    = 8,
    parameter int         PRE_W    = 13,
    parameter logic [7:0] CTRL_KEY = 8'hA5,
    parameter logic [7:0] CNT_KEY  = 8'h5A
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               standby,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [2*CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               irq,
    output logic               wd_ovf,
    output logic               ovf_flag
);
    localparam int BUS_W = 2 * CNT_W;

    logic             mode, run, tick, wrap, flag;
    logic [2:0]       cks;
    logic [CNT_W-1:0] count;
    logic             ctrl_touch, ctrl_wr, cnt_load, rd_flag;
    logic [7:0]       key;

    always_comb begin
        key        = bus_wdata[BUS_W-1 -: 8];
        ctrl_touch = bus_sel && bus_wr && !bus_addr;
        ctrl_wr    = ctrl_touch && (key == CTRL_KEY) && !standby;
        cnt_load   = bus_sel && bus_wr && bus_addr && (key == CNT_KEY);
        rd_flag    = bus_sel && !bus_wr && !bus_addr && flag;
    end

    wdt_ctrl u_ctrl (
        .clk      (clk),
        .por_n    (por_n),
        .standby  (standby),
        .ctrl_wr  (ctrl_wr),
        .wr_touch (ctrl_touch),
        .rd_flag  (rd_flag),
        .wrap     (wrap),
        .tick     (tick),
        .wdata    (bus_wdata[7:0]),
        .mode     (mode),
        .run      (run),
        .cks      (cks),
        .flag     (flag),
        .wd_pulse (wd_ovf)
    );

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .run   (run),
        .cks   (cks),
        .tick  (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .run      (run),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .count    (count),
        .wrap     (wrap)
    );

    always_comb begin
        ovf_flag = flag;
        irq      = flag;
        if (bus_addr)
            bus_rdata = count;
        else
            bus_rdata = CNT_W'({flag, mode, run, 2'b11, cks});
    end

    assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(irq) |-> $past(wrap && !mode));

    assert_key_R8: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && !bus_addr && key != CTRL_KEY) |=> $stable(cks));

endmodule

// File: tb/test_wdt_interval_timer.sv
`timescale 1ns/1ps
module test_wdt_interval_timer;
    logic        clk = 1'b0;
    logic        por_n, standby, bus_sel, bus_wr, bus_addr;
    logic [15:0] bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq, wd_ovf, ovf_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int en_cyc = 0;
    bit done = 1'b0;
    logic [7:0] d;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_interval_timer i_wdt_interval_timer (
        .clk(clk), .por_n(por_n), .standby(standby), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wd_ovf(wd_ovf), .ovf_flag(ovf_flag)
    );

    function automatic int ratio(input int c);
        case (c)
            0: return 2;     1: return 64;    2: return 128;   3: return 256;
            4: return 512;   5: return 1024;  6: return 4096;  default: return 8192;
        endcase
    endfunction

    function automatic int exp_cnt(input int v, input int w, input int m, input int r);
        return (v + m / r - w / r) & 255;
    endfunction

    function automatic int m_now();
        return cyc - en_cyc;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [7:0] k, input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {k, v};
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [7:0] q);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 q = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic enable(input logic [7:0] cfg);
        wr(1'b0, 8'hA5, cfg);
        en_cyc = cyc;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mm;
        void'($urandom(32'd7));
        por_n = 1'b0; standby = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = 1'b0; bus_wdata = '0;
        idle(3);
        por_n = 1'b1;
        idle(1);

        // R2 reset state
        rd(1'b0, d); chk(d, 8'h18, "R2 ctrl reset");
        rd(1'b1, d); chk(d, 0, "R2 count reset");
        chk(irq, 0, "R2 irq"); chk(wd_ovf, 0, "R2 wd_ovf"); chk(ovf_flag, 0, "R2 flag");

        // R8 key, R3 reserved bits, R1 layout
        wr(1'b0, 8'h00, 8'h27); rd(1'b0, d); chk(d, 8'h18, "R8 unkeyed ctrl write");
        wr(1'b0, 8'hA5, 8'h05); rd(1'b0, d); chk(d, 8'h1D, "R3 reserved read 1");
        wr(1'b0, 8'hA5, 8'hE7); rd(1'b0, d); chk(d, 8'h7F, "R5 flag write 1 ignored");
        wr(1'b0, 8'hA5, 8'h00); rd(1'b0, d); chk(d, 8'h18, "R1 disable");

        // R4 / R7 interval overflow
        enable(8'h20);
        wr(1'b1, 8'h5A, 8'hF0);
        while (m_now() < 31) idle(1);
        chk(ovf_flag, 0, "R4 flag before wrap");
        rd(1'b1, d); chk(d, 8'hFF, "R7 count before wrap");
        chk(ovf_flag, 1, "R4 flag on wrap"); chk(irq, 1, "R4 irq on wrap");
        rd(1'b1, d); chk(d, 8'h00, "R4 count wrapped");

        // R5 clear sequence
        wr(1'b0, 8'hA5, 8'h20); chk(ovf_flag, 1, "R5 unread write");
        rd(1'b0, d); chk(d, 8'hB8, "R1 flag read");
        wr(1'b0, 8'hA5, 8'hA0); chk(ovf_flag, 1, "R5 write 1 after read");
        wr(1'b0, 8'hA5, 8'h20); chk(ovf_flag, 1, "R5 disarmed by write");
        rd(1'b0, d);

        // R11 collision: clearing write on the edge of the second wrap
        while (m_now() < 543) idle(1);
        wr(1'b0, 8'hA5, 8'h20);
        chk(ovf_flag, 1, "R11 set beats clear");
        rd(1'b0, d);
        wr(1'b0, 8'hA5, 8'h20);
        chk(ovf_flag, 0, "R5 read then clear");
        chk(irq, 0, "R4 irq follows flag");

        // R8 counter key
        wr(1'b1, 8'hA5, 8'h80);
        mm = m_now(); rd(1'b1, d); chk(d, exp_cnt(8'hF0, 1, mm, 2), "R8 counter key");

        // R6 disable
        wr(1'b0, 8'hA5, 8'h00); idle(1);
        rd(1'b1, d); chk(d, 0, "R6 disabled zero");
        wr(1'b1, 8'h5A, 8'h33); rd(1'b1, d); chk(d, 0, "R6 write ignored");
        idle(20); rd(1'b1, d); chk(d, 0, "R6 stays zero");

        // R12 load on tick edge
        enable(8'h20); idle(1);
        wr(1'b1, 8'h5A, 8'h40);
        for (int i = 0; i < 3; i++) begin
            mm = m_now(); rd(1'b1, d); chk(d, exp_cnt(8'h40, 2, mm, 2), "R12 load on tick");
        end

        // R9 watchdog pulse
        wr(1'b0, 8'hA5, 8'h00);
        enable(8'h60);
        wr(1'b1, 8'h5A, 8'hFE);
        while (m_now() < 8) begin
            chk(wd_ovf, (m_now() == 4 || m_now() == 5) ? 1 : 0, "R9 wd pulse");
            chk(ovf_flag, 0, "R4 no flag in watchdog");
            idle(1);
        end
        wr(1'b0, 8'hA5, 8'h00);

        // R10 standby
        wr(1'b0, 8'hA5, 8'h65); rd(1'b0, d); chk(d, 8'h7D, "R1 mode bits");
        standby = 1'b1; idle(1); standby = 1'b0; idle(1);
        rd(1'b0, d); chk(d, 8'h1D, "R10 standby keeps cks");
        rd(1'b1, d); chk(d, 0, "R10 standby count");
        standby = 1'b1; wr(1'b0, 8'hA5, 8'h27); standby = 1'b0;
        rd(1'b0, d); chk(d, 8'h1D, "R10 write in standby");
        por_n = 1'b0; idle(1); por_n = 1'b1;
        rd(1'b0, d); chk(d, 8'h18, "R10 por clears cks");

        // random runs
        for (int i = 0; i < 24; i++) begin
            int c, r, v, k;
            logic [7:0] badkey;
            c = int'($urandom % 3); r = ratio(c);
            v = int'($urandom % 256); k = int'($urandom % 300) + 2;
            badkey = 8'($urandom);
            if (badkey == 8'hA5) badkey = 8'h00;
            standby = 1'b1; idle(1); standby = 1'b0;
            chk(ovf_flag, 0, "R10 standby clears flag");
            enable(8'(32'h20 | c));
            wr(1'b1, 8'h5A, 8'(v));
            wr(1'b0, badkey, 8'h00);
            idle(k);
            mm = m_now();
            chk(ovf_flag, (mm >= (256 - v) * r) ? 1 : 0, "R4 random flag");
            rd(1'b1, d); chk(d, exp_cnt(v, 1, mm, r), "R7 random count");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule